// File: doc/BRIEF.md
# Host Register and Colour Table Access Port

This block lets a host processor reach two storage spaces through one narrow, synchronous bus of eight data bits and two address bits. The first space is a file of 8-bit control registers. The second is a 256-entry lookup table whose entries each hold three colour bytes. The address bits choose between loading a pointer and moving data. Each pointer moves forward by itself after every data access, so a host can stream a block of registers or a whole table without reloading an address.

The register pointer has three special locations. At one location it parks, so that test data can be read or written again and again. At a second location it does not advance, so that one mask register can be rewritten repeatedly. At a third location it reads a live status byte and discards writes. The table pointer carries a hidden colour phase that counts modulo three through red, green and blue. A table entry changes only when all three bytes arrive: red and green wait in staging registers until the blue byte commits the whole entry.

An access takes place on each rising clock edge at which chip select is low. Read data is registered and appears on the cycle after the read strobe.

Top module: `hbus_access_port`

## Requirements
- R1: The address code selects the target: 2'b00 is the register pointer, 2'b01 is the table address pointer, 2'b10 is register data and 2'b11 is table data. `rd_wr` high makes the access a read and low makes it a write. A pointer read returns the pointer value, zero-extended.
- R2: When `cs_n` is high, no pointer, register, table entry or colour phase changes.
- R3: After each register data access, the register pointer steps up by one and wraps from 0xFF to 0x00, except at the addresses named in R4 and R5.
- R4: When the register pointer is at 0x40, data accesses leave it at 0x40.
- R5: When the register pointer is at 0x50, data accesses leave it at 0x50. Repeated writes there land in that one register and in no other register.
- R6: Register location 0x1F reads the `status_val` input. A write to it is discarded, and the pointer still advances to 0x20.
- R7: Table data accesses step through the colour bytes red, green, blue in that order. Writing the table pointer returns the colour phase to red. A table read returns the byte of the current colour of the addressed entry.
- R8: A table entry is updated only when its blue byte is written. Red and green bytes that are followed by a pointer write, and not by a blue write, leave the entry unchanged.
- R9: After the blue byte of an entry is accessed, the table address steps up by one and wraps from 255 to 0. Red and green accesses do not move the table address.
- R10: `rdata` takes the value of a read on the clock edge that performs the read, and it keeps that value through writes and idle cycles until the next read.
- R11: After reset, both pointers are 0, the colour phase is red, every control register is 0x00 and `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; accesses are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select; one access per edge while low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Target select (pointer or data, register or table) |
| wdata | input | 8 | Write data from the host |
| status_val | input | 8 | Live byte returned at the status location |
| rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with its default parameters: an 8-bit register pointer with park, hold and status addresses at 0x40, 0x50 and 0x1F, and a 256-entry table. With these values, a few short streams reach every special register address and cover the register-pointer wrap at 0xFF. Loading the table pointer with 255 puts the table wrap to entry 0 one entry away. Because the table is small, the bench can check it against a full reference copy. Partial red and green writes followed by a pointer reload show that uncommitted bytes never reach memory.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  typedef enum logic [1:0] {
    SEL_REG_PTR = 2'b00,
    SEL_LUT_PTR = 2'b01,
    SEL_REG_DAT = 2'b10,
    SEL_LUT_DAT = 2'b11
  } bus_sel_e;

  typedef enum logic [1:0] {
    COL_RED = 2'd0,
    COL_GRN = 2'd1,
    COL_BLU = 2'd2
  } colour_e;

  // modulo-3 successor of the colour phase
  function automatic colour_e colour_next(input colour_e c);
    case (c)
      COL_RED: return COL_GRN;
      COL_GRN: return COL_BLU;
      default: return COL_RED;
    endcase
  endfunction

endpackage

// File: rtl/hbus_decode.sv
module hbus_decode
  import hbus_pkg::*;
(
  input  logic       cs_n,
  input  logic       rd_wr,
  input  logic [1:0] addr,
  output logic       ev_reg_ptr_wr,
  output logic       ev_lut_ptr_wr,
  output logic       ev_reg_dat_wr,
  output logic       ev_reg_dat_rd,
  output logic       ev_lut_dat_wr,
  output logic       ev_lut_dat_rd,
  output logic       ev_rd,
  output bus_sel_e   sel
);

  logic strobe;

  always_comb begin
    strobe = ~cs_n;
    sel    = bus_sel_e'(addr);
    ev_rd  = strobe & rd_wr;
    ev_reg_ptr_wr = strobe & ~rd_wr & (sel == SEL_REG_PTR);
    ev_lut_ptr_wr = strobe & ~rd_wr & (sel == SEL_LUT_PTR);
    ev_reg_dat_wr = strobe & ~rd_wr & (sel == SEL_REG_DAT);
    ev_reg_dat_rd = strobe &  rd_wr & (sel == SEL_REG_DAT);
    ev_lut_dat_wr = strobe & ~rd_wr & (sel == SEL_LUT_DAT);
    ev_lut_dat_rd = strobe &  rd_wr & (sel == SEL_LUT_DAT);
  end

endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] PARK_AT   = 8'h40,
  parameter logic [AW-1:0] HOLD_AT   = 8'h50,
  parameter logic [AW-1:0] STATUS_AT = 8'h1F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_wr,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] status_val,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] rd_byte
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] regs [DEPTH];
  logic          dat_access;
  logic          store_en;

  // next pointer after a data access
  function automatic logic [AW-1:0] ptr_advance(input logic [AW-1:0] p);
    if (p == PARK_AT || p == HOLD_AT) return p;
    return p + AW'(1);
  endfunction

  assign dat_access = dat_wr | dat_rd;
  assign store_en   = dat_wr & (ptr != STATUS_AT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      if (store_en) regs[ptr] <= wdata;
      if (ptr_wr)          ptr <= AW'(wdata);
      else if (dat_access) ptr <= ptr_advance(ptr);
    end
  end

  assign rd_byte = (ptr == STATUS_AT) ? status_val : regs[ptr];

  // R4: parked pointer stays parked
  a_r4_park_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_access && !ptr_wr && ptr == PARK_AT) |=> (ptr == PARK_AT));

  // R5: hold address does not advance
  a_r5_hold_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_access && !ptr_wr && ptr == HOLD_AT) |=> (ptr == HOLD_AT));

  // R3, R6: ordinary addresses (status included) step by one
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_access && !ptr_wr && ptr != PARK_AT && ptr != HOLD_AT)
      |=> (ptr == $past(ptr) + AW'(1)));

  // R6: status slot never stored
  a_r6_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && ptr == STATUS_AT) |=> $stable(regs[STATUS_AT]));

endmodule

// File: rtl/hbus_lut.sv
module hbus_lut
  import hbus_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_wr,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] ptr,
  output colour_e       col,
  output logic [DW-1:0] rd_byte
);

  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned EW    = 3 * DW;

  logic [EW-1:0] mem [DEPTH];
  logic [DW-1:0] stage_r, stage_g;
  logic          dat_access;
  logic          commit;

  function automatic logic [DW-1:0] pick_colour(input logic [EW-1:0] e,
                                                input colour_e c);
    case (c)
      COL_RED: return e[EW-1 -: DW];
      COL_GRN: return e[2*DW-1 -: DW];
      default: return e[DW-1:0];
    endcase
  endfunction

  assign dat_access = dat_wr | dat_rd;
  assign commit     = dat_wr & (col == COL_BLU);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      col     <= COL_RED;
      stage_r <= '0;
      stage_g <= '0;
    end else begin
      if (dat_wr && col == COL_RED) stage_r <= wdata;
      if (dat_wr && col == COL_GRN) stage_g <= wdata;
      if (ptr_wr) begin
        ptr <= AW'(wdata);
        col <= COL_RED;
      end else if (dat_access) begin
        col <= colour_next(col);
        if (col == COL_BLU) ptr <= ptr + AW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[ptr] <= {stage_r, stage_g, wdata};
  end

  assign rd_byte = pick_colour(mem[ptr], col);

  // R7: phase stays within its three legal codes
  a_r7_col_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (col != 2'd3));

  // R7: pointer load restarts at red
  a_r7_ptr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> (col == COL_RED));

  // R9: red/green accesses leave the address alone
  a_r9_hold_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_access && !ptr_wr && col != COL_BLU) |=> $stable(ptr));

  // R9: blue access moves to next entry, wrapping at the top
  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_access && !ptr_wr && col == COL_BLU && ptr == AW'(DEPTH-1))
      |=> (ptr == '0 && col == COL_RED));

endmodule

// File: rtl/hbus_access_port.sv
module hbus_access_port
  import hbus_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned REG_AW = 8,
  parameter int unsigned LUT_AW = 8,
  parameter logic [REG_AW-1:0] PARK_AT   = 8'h40,
  parameter logic [REG_AW-1:0] HOLD_AT   = 8'h50,
  parameter logic [REG_AW-1:0] STATUS_AT = 8'h1F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] status_val,
  output logic [DW-1:0] rdata
);

  logic ev_reg_ptr_wr, ev_lut_ptr_wr;
  logic ev_reg_dat_wr, ev_reg_dat_rd;
  logic ev_lut_dat_wr, ev_lut_dat_rd;
  logic ev_rd;
  bus_sel_e sel;

  logic [REG_AW-1:0] reg_ptr;
  logic [LUT_AW-1:0] lut_ptr;
  colour_e           lut_col;
  logic [DW-1:0]     reg_byte, lut_byte;
  logic [DW-1:0]     rd_next;

  hbus_decode u_dec (
    .cs_n          (cs_n),
    .rd_wr         (rd_wr),
    .addr          (addr),
    .ev_reg_ptr_wr (ev_reg_ptr_wr),
    .ev_lut_ptr_wr (ev_lut_ptr_wr),
    .ev_reg_dat_wr (ev_reg_dat_wr),
    .ev_reg_dat_rd (ev_reg_dat_rd),
    .ev_lut_dat_wr (ev_lut_dat_wr),
    .ev_lut_dat_rd (ev_lut_dat_rd),
    .ev_rd         (ev_rd),
    .sel           (sel)
  );

  hbus_regfile #(
    .DW(DW), .AW(REG_AW),
    .PARK_AT(PARK_AT), .HOLD_AT(HOLD_AT), .STATUS_AT(STATUS_AT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_wr     (ev_reg_ptr_wr),
    .dat_wr     (ev_reg_dat_wr),
    .dat_rd     (ev_reg_dat_rd),
    .wdata      (wdata),
    .status_val (status_val),
    .ptr        (reg_ptr),
    .rd_byte    (reg_byte)
  );

  hbus_lut #(.DW(DW), .AW(LUT_AW)) u_lut (
    .clk     (clk),
    .rst_n   (rst_n),
    .ptr_wr  (ev_lut_ptr_wr),
    .dat_wr  (ev_lut_dat_wr),
    .dat_rd  (ev_lut_dat_rd),
    .wdata   (wdata),
    .ptr     (lut_ptr),
    .col     (lut_col),
    .rd_byte (lut_byte)
  );

  always_comb begin
    case (sel)
      SEL_REG_PTR: rd_next = DW'(reg_ptr);
      SEL_LUT_PTR: rd_next = DW'(lut_ptr);
      SEL_REG_DAT: rd_next = reg_byte;
      default:     rd_next = lut_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (ev_rd) rdata <= rd_next;
  end

  // R2: deselected bus leaves all pointer state alone
  a_r2_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(reg_ptr) && $stable(lut_ptr) && $stable(lut_col)));

  // R10: read data held between reads
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rd |=> $stable(rdata));

endmodule

// File: tb/tb_hbus_access_port.sv
`timescale 1ns/1ps
module tb_hbus_access_port;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n;
  logic       rd_wr;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] status_val;
  logic [7:0] rdata;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  hbus_access_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr),
    .addr(addr), .wdata(wdata), .status_val(status_val), .rdata(rdata)
  );

  // reference model
  logic [7:0] m_reg [256];
  logic [7:0] m_lut [256][3];
  logic [7:0] m_stage [3];
  logic [7:0] bp_reg, bp_lut;
  int         bcol;

  // scoreboard
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rst_n && !cs_n && rd_wr;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: actual=%02h expected=none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus(input logic [1:0] a, input logic rw, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; addr = a; rd_wr = rw; wdata = d;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  function automatic logic [7:0] reg_step(input logic [7:0] p);
    if (p == 8'h40 || p == 8'h50) return p;
    return p + 8'd1;
  endfunction

  task automatic lut_step();
    if (bcol == 2) begin bcol = 0; bp_lut = bp_lut + 8'd1; end
    else bcol = bcol + 1;
  endtask

  task automatic set_reg_ptr(input logic [7:0] v);
    bp_reg = v; bus(2'b00, 1'b0, v);
  endtask

  task automatic set_lut_ptr(input logic [7:0] v);
    bp_lut = v; bcol = 0; bus(2'b01, 1'b0, v);
  endtask

  task automatic wr_reg(input logic [7:0] v);
    if (bp_reg != 8'h1F) m_reg[bp_reg] = v;
    bp_reg = reg_step(bp_reg);
    bus(2'b10, 1'b0, v);
  endtask

  task automatic rd_reg(input string tag);
    exp_q.push_back(bp_reg == 8'h1F ? status_val : m_reg[bp_reg]);
    tag_q.push_back(tag);
    bp_reg = reg_step(bp_reg);
    bus(2'b10, 1'b1, 8'h00);
  endtask

  task automatic rd_reg_ptr(input string tag);
    exp_q.push_back(bp_reg); tag_q.push_back(tag);
    bus(2'b00, 1'b1, 8'h00);
  endtask

  task automatic rd_lut_ptr(input string tag);
    exp_q.push_back(bp_lut); tag_q.push_back(tag);
    bus(2'b01, 1'b1, 8'h00);
  endtask

  task automatic wr_lut(input logic [7:0] v);
    m_stage[bcol] = v;
    if (bcol == 2) begin
      m_lut[bp_lut][0] = m_stage[0];
      m_lut[bp_lut][1] = m_stage[1];
      m_lut[bp_lut][2] = v;
    end
    lut_step();
    bus(2'b11, 1'b0, v);
  endtask

  task automatic rd_lut(input string tag);
    exp_q.push_back(m_lut[bp_lut][bcol]); tag_q.push_back(tag);
    lut_step();
    bus(2'b11, 1'b1, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) m_reg[i] = 8'h00;
    bp_reg = 8'h00; bp_lut = 8'h00; bcol = 0;
    cs_n = 1'b1; rd_wr = 1'b0; addr = 2'b00; wdata = 8'h00;
    status_val = 8'h5C;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 rdata after reset", rdata, 8'h00);
    rd_reg_ptr("R11 reg pointer reset");
    rd_lut_ptr("R11 table pointer reset");
    set_reg_ptr(8'h07);
    rd_reg("R11 register cleared");

    // R1/R3 stream of writes then readback
    set_reg_ptr(8'h10);
    wr_reg(8'h11); wr_reg(8'h12); wr_reg(8'h13);
    rd_reg_ptr("R3 pointer after three writes");
    set_reg_ptr(8'h10);
    rd_reg("R1 reg data 0x10"); rd_reg("R3 reg data 0x11"); rd_reg("R3 reg data 0x12");

    // R3 wrap at 0xFF
    set_reg_ptr(8'hFF);
    wr_reg(8'hC3);
    rd_reg_ptr("R3 pointer wraps to 0");

    // R6 status location
    set_reg_ptr(8'h1E);
    wr_reg(8'hAA); wr_reg(8'h55); wr_reg(8'h77);
    set_reg_ptr(8'h1F);
    rd_reg("R6 status read returns input");
    rd_reg_ptr("R6 pointer advanced past status");
    rd_reg("R6 byte after status");

    // R4 park address
    set_reg_ptr(8'h3F);
    wr_reg(8'h01); wr_reg(8'h02); wr_reg(8'h03);
    rd_reg_ptr("R4 pointer parked at 0x40");
    rd_reg("R4 repeated read at 0x40");
    rd_reg("R4 second read at 0x40");

    // R5 hold address
    set_reg_ptr(8'h50);
    wr_reg(8'hA1); wr_reg(8'hA2);
    rd_reg_ptr("R5 pointer held at 0x50");
    rd_reg("R5 last write kept");
    set_reg_ptr(8'h51);
    rd_reg("R5 neighbour untouched");

    // R2 deselected bus
    set_reg_ptr(8'h22);
    @(negedge clk);
    cs_n = 1'b1; addr = 2'b00; rd_wr = 1'b0; wdata = 8'h99;
    @(negedge clk);
    addr = 2'b11; wdata = 8'h66;
    @(negedge clk);
    rd_reg_ptr("R2 pointer unchanged by deselected write");
    set_lut_ptr(8'h30);
    wr_lut(8'h01); wr_lut(8'h02); wr_lut(8'h03);
    set_lut_ptr(8'h30);
    rd_lut("R2 table red intact");

    // R7/R9 two entries
    set_lut_ptr(8'h05);
    wr_lut(8'h10); wr_lut(8'h20); wr_lut(8'h30);
    wr_lut(8'h40); wr_lut(8'h50); wr_lut(8'h60);
    rd_lut_ptr("R9 table pointer after two entries");
    set_lut_ptr(8'h05);
    rd_lut("R7 red 5"); rd_lut("R7 green 5"); rd_lut("R7 blue 5");
    rd_lut("R7 red 6");
    rd_lut_ptr("R9 pointer still 6 after red");
    rd_lut("R7 green 6"); rd_lut("R7 blue 6");

    // R8 partial write is dropped
    set_lut_ptr(8'h05);
    wr_lut(8'hEE); wr_lut(8'hDD);
    set_lut_ptr(8'h05);
    rd_lut("R8 red unchanged"); rd_lut("R8 green unchanged"); rd_lut("R8 blue unchanged");

    // R9 wrap at top entry
    set_lut_ptr(8'hFF);
    wr_lut(8'h0A); wr_lut(8'h0B); wr_lut(8'h0C);
    rd_lut_ptr("R9 table pointer wraps to 0");
    set_lut_ptr(8'hFF);
    rd_lut("R9 red 255"); rd_lut("R9 green 255"); rd_lut("R9 blue 255");

    // R10 rdata held through writes and idle
    repeat (2) @(negedge clk);
    set_reg_ptr(8'h60);
    wr_reg(8'h12);
    repeat (3) @(negedge clk);
    check("R10 rdata held", rdata, 8'h0C);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule